// File: doc/BRIEF.md
# Direct-Mapped Read Cache

This block sits between a byte-addressed requester and a slower main memory and serves reads only. Each request address is split into three fields: the low bits choose a byte inside a line, the middle bits choose one line of the cache, and the upper bits form a tag. The chosen line's stored tag is compared with the tag field, and the line's valid flag is checked. When both agree the access is a hit, and the requested byte is returned one clock after the request is accepted.

On a miss the block stops accepting requests. It asks memory for the whole line-aligned block and waits for an acknowledge that carries the complete line in a single beat. It then writes the line, the tag and the valid flag into the chosen line slot, replacing whatever was there before. In the next cycle it returns the requested byte from the fetched data. All valid flags clear at reset, so the cache starts empty.

Top module: `dm_read_cache`

## Requirements
- R1: For the default parameters (16-bit address, 8 lines, 4-byte lines), address bits [1:0] select the byte in a line, bits [4:2] select the line and bits [15:5] are the tag. Addresses that differ only in the line-select bits occupy separate lines and do not evict each other.
- R2: After reset every line is invalid. Outputs are req_ready=1, rsp_valid=0 and mem_req=0, and the first read of any address misses.
- R3: An accepted request whose line is valid and whose stored tag equals the address tag is a hit. The cycle after acceptance shows rsp_valid=1 and the byte, with no memory request.
- R4: An accepted miss raises mem_req in the next cycle, with mem_addr equal to the request address with its two byte-select bits cleared. mem_req and mem_addr stay unchanged and req_ready stays 0 until mem_ack is seen.
- R5: A fill stores the tag, the line data and a set valid flag, so a later read of the same address hits without a memory request.
- R6: Byte i of mem_data (bits 8i+7 down to 8i) becomes byte i of the line. Every other byte of the same block hits after one fill and returns its own byte.
- R7: A fill overwrites the previous contents of its line. After a block with the same line-select bits but a different tag is fetched, the earlier block misses again.
- R8: In the cycle after mem_ack is sampled, rsp_valid=1 with the requested byte, mem_req=0 and req_ready=1.
- R9: rsp_valid is high for exactly one cycle per accepted request and is never high without one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Requester presents a read |
| req_addr | input | ADDR_W | Byte address of the read |
| req_ready | output | 1 | Cache can accept a read this cycle |
| rsp_valid | output | 1 | Read result is present this cycle |
| rsp_data | output | 8 | Byte that was read |
| mem_req | output | 1 | Line fetch request to memory |
| mem_addr | output | ADDR_W | Line-aligned address of the fetch |
| mem_ack | input | 1 | Memory returns the line this cycle |
| mem_data | input | 8<<OFF_W | Full line from memory, byte 0 in the low bits |

## Verification
The assertions assume that memory raises mem_ack only while mem_req is high and that mem_data is valid in the same cycle as the acknowledge. They also assume the requester treats a read as taken only when req_valid and req_ready are both high. The bench's memory model acknowledges only during a pending fetch, after a chosen latency, and drives the line in that same cycle. The bench raises req_valid only in cycles where it has already seen req_ready high, and drops it after the accepting edge. The latency varies from one cycle to several so that both short and long fills are covered.

// File: rtl/drc_pkg.sv
// Shared types for the direct-mapped read cache.
package drc_pkg;
    // Controller phases: serving lookups, or waiting on a line fetch.
    typedef enum logic [0:0] {
        ST_LOOKUP = 1'b0,
        ST_FILL   = 1'b1
    } ctrl_state_t;
endpackage

// File: rtl/drc_addr_split.sv
// Splits a byte address into tag, line index and byte offset.
// Assumes ADDR_W > IDX_W + OFF_W. Purely combinational.
module drc_addr_split #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2,
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [IDX_W-1:0]  idx,
    output logic [OFF_W-1:0]  off
);
    // Field extraction: offset lowest, index next, tag on top.
    always_comb begin
        off = addr[OFF_W-1:0];
        idx = addr[OFF_W +: IDX_W];
        tag = addr[ADDR_W-1 -: TAG_W];
    end
endmodule

// File: rtl/drc_byte_pick.sv
// Selects one byte lane of a line by offset. Byte i sits at bits 8i+7:8i.
module drc_byte_pick #(
    parameter int OFF_W  = 2,
    localparam int LANES  = 1 << OFF_W,
    localparam int LINE_W = 8 * LANES
) (
    input  logic [LINE_W-1:0] line,
    input  logic [OFF_W-1:0]  off,
    output logic [7:0]        byte_o
);
    logic [7:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = line[8*g +: 8];
    end

    // Offset-driven lane multiplexer.
    always_comb byte_o = lane[off];
endmodule

// File: rtl/drc_line_store.sv
// Valid, tag and data storage for all lines, held in flops.
// One combinational read port that also compares tags, and one write port used by fills.
// Only the valid flags are reset; tag and data are don't-care while invalid.
module drc_line_store #(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 11,
    parameter int LINE_W = 32,
    localparam int LINES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line
);
    logic [LINES-1:0]             valid_q;
    logic [LINES-1:0][TAG_W-1:0]  tag_q;
    logic [LINES-1:0][LINE_W-1:0] data_q;
    logic [LINES-1:0]             line_we;

    for (genvar g = 0; g < LINES; g++) begin : g_we
        assign line_we[g] = wr_en && (wr_idx == IDX_W'(g));
    end

    // Valid flags: cleared at reset, set by a fill of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_q | line_we;
        end
    end

    // Tag and data arrays: a fill overwrites the selected line.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (line_we[i]) begin
                tag_q[i]  <= wr_tag;
                data_q[i] <= wr_line;
            end
        end
    end

    // Lookup: a hit needs a set valid flag and a matching stored tag.
    always_comb begin
        rd_hit  = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_line = data_q[rd_idx];
    end
endmodule

// File: rtl/drc_ctrl.sv
// Sequencing for the read cache: takes a request, steers a hit straight to the
// response, and on a miss holds a fetch request until memory acknowledges it.
// Assumes mem_ack is raised only while mem_req is high.
module drc_ctrl
    import drc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic lookup_hit,
    input  logic mem_ack,
    output logic req_ready,
    output logic mem_req,
    output logic hit_take,
    output logic miss_take,
    output logic fill_we
);
    ctrl_state_t state_q, state_d;

    // Handshake decode for the current phase.
    always_comb begin
        req_ready = (state_q == ST_LOOKUP);
        mem_req   = (state_q == ST_FILL);
        hit_take  = req_valid && req_ready && lookup_hit;
        miss_take = req_valid && req_ready && !lookup_hit;
        fill_we   = mem_req && mem_ack;
    end

    // Next phase: a miss enters the fill, an acknowledge leaves it.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_LOOKUP: if (miss_take) state_d = ST_FILL;
            ST_FILL:   if (mem_ack)   state_d = ST_LOOKUP;
            default:   state_d = ST_LOOKUP;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/dm_read_cache.sv
// Direct-mapped read-only cache. A hit answers one cycle after acceptance. A miss
// stalls, fetches the whole line in one acknowledged beat, writes it into the
// line slot and answers in the next cycle.
// Assumes the requester treats a read as taken only on req_valid && req_ready.
module dm_read_cache #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2,
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int LINE_W = 8 << OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [7:0]        rsp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_data
);
    logic [TAG_W-1:0]  req_tag, tag_q;
    logic [IDX_W-1:0]  req_idx, idx_q;
    logic [OFF_W-1:0]  req_off, off_q;
    logic              lookup_hit;
    logic [LINE_W-1:0] lookup_line;
    logic              hit_take, miss_take, fill_we;
    logic [7:0]        hit_byte, fill_byte;
    logic              rsp_valid_q;
    logic [7:0]        rsp_data_q;

    drc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
        .addr (req_addr),
        .tag  (req_tag),
        .idx  (req_idx),
        .off  (req_off)
    );

    drc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (req_idx),
        .rd_tag  (req_tag),
        .rd_hit  (lookup_hit),
        .rd_line (lookup_line),
        .wr_en   (fill_we),
        .wr_idx  (idx_q),
        .wr_tag  (tag_q),
        .wr_line (mem_data)
    );

    drc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .lookup_hit (lookup_hit),
        .mem_ack    (mem_ack),
        .req_ready  (req_ready),
        .mem_req    (mem_req),
        .hit_take   (hit_take),
        .miss_take  (miss_take),
        .fill_we    (fill_we)
    );

    drc_byte_pick #(.OFF_W(OFF_W)) u_pick_hit (
        .line   (lookup_line),
        .off    (req_off),
        .byte_o (hit_byte)
    );

    drc_byte_pick #(.OFF_W(OFF_W)) u_pick_fill (
        .line   (mem_data),
        .off    (off_q),
        .byte_o (fill_byte)
    );

    // Miss capture: hold the address fields for the whole fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
            idx_q <= '0;
            off_q <= '0;
        end else if (miss_take) begin
            tag_q <= req_tag;
            idx_q <= req_idx;
            off_q <= req_off;
        end
    end

    // Response register: a one-cycle pulse after a hit or after a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= hit_take || fill_we;
            if (hit_take)     rsp_data_q <= hit_byte;
            else if (fill_we) rsp_data_q <= fill_byte;
        end
    end

    // Outputs: line-aligned fetch address and the registered response.
    always_comb begin
        mem_addr  = {tag_q, idx_q, {OFF_W{1'b0}}};
        rsp_valid = rsp_valid_q;
        rsp_data  = rsp_data_q;
    end
endmodule

// File: rtl/dm_read_cache_chk.sv
// Protocol checks for dm_read_cache, attached through bind.
// Assumes mem_ack is raised only while mem_req is high.
module dm_read_cache_chk #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              lookup_hit
);
    a_r4_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r4_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    a_r4_stall: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    a_r2_fetch_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(req_valid && req_ready && !lookup_hit));

    a_r3_hit_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && lookup_hit) |=> (rsp_valid && !mem_req));

    a_r8_fill_done: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (rsp_valid && !mem_req && req_ready));

    a_r9_rsp_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready && lookup_hit) || $past(mem_req && mem_ack)));
endmodule

bind dm_read_cache dm_read_cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .lookup_hit (lookup_hit)
);

// File: tb/sim_dm_read_cache.sv
// Bench: behavioural cache model (arrays of integers) plus a memory with chosen latency.
module sim_dm_read_cache;
    localparam int AW = 16;
    localparam int LW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [7:0]    rsp_data;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_ack = 1'b0;
    logic [LW-1:0] mem_data = '0;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    bit m_valid [8];
    int m_tag   [8];

    always #2.5 clk = ~clk;

    dm_read_cache u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data)
    );

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: act=%0d cycles exp<=50000", cyc);
            finish_run();
        end
    end

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    // Memory contents: a computed byte per address.
    function automatic logic [7:0] mem_byte(input int a);
        return 8'((a * 37 + 11) ^ (a >> 7));
    endfunction

    function automatic logic [LW-1:0] mem_line(input int base);
        logic [LW-1:0] l;
        for (int b = 0; b < 4; b++) l[8*b +: 8] = mem_byte(base + b);
        return l;
    endfunction

    // Idle cycles: nothing may be reported or fetched (R9).
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R9", "idle rsp_valid", rsp_valid, 0);
            chk("R9", "idle mem_req", mem_req, 0);
        end
    endtask

    // One read, checked every cycle against the model. Called at a negedge.
    task automatic do_read(input int a, input int lat, input string rq);
        int  idx = (a >> 2) & 7;
        int  tg  = a >> 5;
        bit  hit = m_valid[idx] && (m_tag[idx] == tg);
        chk(rq, "ready before request", req_ready, 1);
        req_valid = 1'b1;
        req_addr  = AW'(a);
        @(negedge clk);
        req_valid = 1'b0;
        if (hit) begin
            chk("R3", "hit rsp_valid", rsp_valid, 1);
            chk("R3", "hit no fetch", mem_req, 0);
            chk(rq, "hit byte", rsp_data, mem_byte(a));
        end else begin
            for (int c = 0; c < lat; c++) begin
                chk("R4", "fetch req", mem_req, 1);
                chk("R4", "fetch addr", mem_addr, a & ~3);
                chk("R4", "stall", req_ready, 0);
                chk("R9", "no early rsp", rsp_valid, 0);
                if (c == lat - 1) begin
                    mem_ack  = 1'b1;
                    mem_data = mem_line(a & ~3);
                end
                @(negedge clk);
            end
            mem_ack  = 1'b0;
            mem_data = '0;
            chk("R8", "fill rsp_valid", rsp_valid, 1);
            chk("R8", "no second fetch", mem_req, 0);
            chk("R8", "ready again", req_ready, 1);
            chk(rq, "fill byte", rsp_data, mem_byte(a));
            m_valid[idx] = 1'b1;
            m_tag[idx]   = tg;
        end
    endtask

    // Forces a hit/miss expectation in addition to the model.
    task automatic expect_kind(input int a, input bit want_hit, input string rq);
        int idx = (a >> 2) & 7;
        chk(rq, "model hit", (m_valid[idx] && m_tag[idx] == (a >> 5)), want_hit);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin m_valid[i] = 0; m_tag[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", "reset ready", req_ready, 1);
        chk("R2", "reset rsp_valid", rsp_valid, 0);
        chk("R2", "reset mem_req", mem_req, 0);

        // R2: cold miss
        expect_kind('h1234, 0, "R2");
        do_read('h1234, 3, "R2");
        idle(1);
        // R6: other bytes of the block hit; R5: same address hits
        do_read('h1235, 1, "R6");
        do_read('h1236, 1, "R6");
        do_read('h1237, 1, "R6");
        do_read('h1234, 1, "R5");
        idle(2);
        // R7: conflicting tag in the same line evicts
        expect_kind('h5634, 0, "R7");
        do_read('h5634, 2, "R7");
        expect_kind('h1234, 0, "R7");
        do_read('h1234, 4, "R7");
        do_read('h1234, 1, "R5");
        // R1: fill every line, then all hit
        for (int i = 0; i < 8; i++) do_read('h0A00 + i * 4 + (i % 4), 1 + (i % 3), "R1");
        for (int i = 0; i < 8; i++) begin
            expect_kind('h0A00 + i * 4 + ((i + 1) % 4), 1, "R1");
            do_read('h0A00 + i * 4 + ((i + 1) % 4), 1, "R1");
        end
        idle(1);
        // R7: high tag conflicts, then R3 back-to-back hits
        do_read('hFFE0, 5, "R7");
        do_read('hFFE3, 1, "R3");
        do_read('h0A00, 1, "R7");
        do_read('h0A01, 1, "R3");
        idle(3);
        finish_run();
    end
endmodule